// File: doc/BRIEF.md
# Block-transfer address sequencer

This block turns one decoded load/store-multiple instruction into a train of single-word memory transfers. On a start strobe it captures the addressing controls (pre/post indexing, up/down direction, user-bank flag, writeback, load/store direction and bank half), a 16-bit register mask and the base address. It then issues one transfer per set mask bit. Each transfer carries an address, a 5-bit register index and a direction. Transfers are paced by a valid/ready handshake toward memory.

The mask reaches only one half of a 32-entry register file, and the bank bit picks which half. Registers always go out lowest index first, at the lowest address. The direction bit only decides whether the block of words sits above or below the base. When the whole train has been accepted, a one-cycle completion pulse is raised. If writeback was requested, the updated base is presented with that pulse.

Top module: `lsm_sequencer`

## Requirements
- R1: A start is taken only while `busy` is low. A start raised while an operation is in flight, including its completion cycle, changes neither the running train nor what follows it.
- R2: Within one operation, register indices are issued in strictly ascending order. Every set mask bit is visited exactly once.
- R3: The issued index is `{bank, position}`. Here `position` is the mask bit number (bit 0 = lowest register of the half) and `bank` is the captured bank bit, so bit i selects register i when bank=0 and register 16+i when bank=1.
- R4: Each transfer after the first uses the previous address plus 4.
- R5: With n set mask bits, the first address is: base+4 when pre=1 and up=1; base when pre=0 and up=1; base-4n when pre=1 and up=0; base-4n+4 when pre=0 and up=0.
- R6: `wb_valid` is high only together with `done`, and only when writeback was requested. `wb_data` is then base+4n for up=1 or base-4n for up=0, and `wb_reg` is the captured base register index.
- R7: An all-zero mask produces no transfer, and `done` is raised in the cycle after the start. If writeback was requested, it carries the unchanged base.
- R8: While `mem_valid` is high and `mem_ready` is low, the address, the index and `mem_valid` itself hold.
- R9: Exactly n transfers complete. `done` is a single-cycle pulse in the cycle after the last accepted transfer.
- R10: Every transfer presents `mem_load` equal to the captured load bit (1 = load, 0 = store) and `mem_usr` equal to the captured user-bank flag.
- R11: While reset is applied, and in the cycle after it, `mem_valid`, `done`, `wb_valid` and `busy` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin an operation with the values on the i_* inputs |
| i_pre | input | 1 | 1 = step before each access, 0 = after |
| i_up | input | 1 | 1 = words above base, 0 = below |
| i_usr | input | 1 | User-bank transfer flag, passed to each transfer |
| i_wb | input | 1 | Request writeback of the final base |
| i_load | input | 1 | 1 = load, 0 = store |
| i_bank | input | 1 | Register half: 0 = low 16, 1 = high 16 |
| i_mask | input | 16 | Register selection mask |
| i_base_reg | input | 5 | Index of the base register |
| i_base | input | 32 | Base address |
| mem_ready | input | 1 | Memory accepts the current transfer |
| mem_valid | output | 1 | A transfer is presented |
| mem_addr | output | 32 | Transfer address |
| mem_reg | output | 5 | Register index of the transfer |
| mem_load | output | 1 | Transfer direction |
| mem_usr | output | 1 | User-bank flag of the transfer |
| busy | output | 1 | An operation is in flight |
| done | output | 1 | One-cycle completion pulse |
| wb_valid | output | 1 | Writeback of the base is due |
| wb_reg | output | 5 | Base register to update |
| wb_data | output | 32 | Updated base value |

## Verification
The assertions assume that memory holds `mem_ready` in a defined state, and that the i_* fields are stable in the cycle `start` is high. They also assume that base arithmetic wraps modulo 2^32 with no fault. The stimulus drives every field on the falling edge together with `start`, and returns `mem_ready` low between operations. It keeps bases far from the wrap point, so that the expected addresses computed in the bench never overflow. Stalls are inserted in a fixed rhythm, so that the hold rule is exercised on the same transfers whose addresses are checked.

// File: rtl/lsm_pkg.sv
package lsm_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_XFER = 2'd1,
    ST_DONE = 2'd2
  } lsm_state_e;

  // controls kept for the whole operation
  typedef struct packed {
    logic bank;
    logic wb;
    logic load;
    logic usr;
  } lsm_ctrl_t;
endpackage

// File: rtl/lsm_lowest_scan.sv
module lsm_lowest_scan #(
  parameter int MW = 16,
  localparam int IW = $clog2(MW)
) (
  input  logic [MW-1:0] vec,
  output logic          found,
  output logic [IW-1:0] idx,
  output logic [MW-1:0] rest
);
  logic [MW:0]   below;
  logic [MW-1:0] onehot;

  assign below[0] = 1'b0;
  for (genvar g = 0; g < MW; g++) begin : g_chain
    assign onehot[g]  = vec[g] & ~below[g];
    assign below[g+1] = below[g] | vec[g];
  end

  assign found = below[MW];
  assign rest  = vec & ~onehot;

  always_comb begin
    idx = '0;
    for (int i = 0; i < MW; i++)
      if (onehot[i]) idx = idx | IW'(i);
  end

  // R2: exactly one bit is removed per scan step
  always_comb begin
    if (found)
      assert ($countones(vec) == $countones(rest) + 1)
        else $error("p_one_removed_r2");
  end
endmodule

// File: rtl/lsm_addr_calc.sv
module lsm_addr_calc #(
  parameter int AW = 32,
  parameter int MW = 16,
  localparam int CW = $clog2(MW + 1)
) (
  input  logic [AW-1:0] base,
  input  logic [MW-1:0] mask,
  input  logic          pre,
  input  logic          up,
  output logic [AW-1:0] first_addr,
  output logic [AW-1:0] final_base
);
  logic [CW-1:0] cnt;
  logic [AW-1:0] span;
  logic [AW-1:0] four;

  always_comb begin
    cnt = '0;
    for (int i = 0; i < MW; i++)
      cnt = cnt + CW'(mask[i]);
  end

  assign four = AW'(4);
  assign span = AW'(cnt) << 2;

  always_comb begin
    if (up) begin
      first_addr = pre ? base + four : base;
      final_base = base + span;
    end else begin
      first_addr = pre ? base - span : base - span + four;
      final_base = base - span;
    end
  end
endmodule

// File: rtl/lsm_sequencer.sv
module lsm_sequencer
  import lsm_pkg::*;
#(
  parameter int AW = 32,
  parameter int MW = 16,
  localparam int IW = $clog2(MW),
  localparam int RW = IW + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic          i_pre,
  input  logic          i_up,
  input  logic          i_usr,
  input  logic          i_wb,
  input  logic          i_load,
  input  logic          i_bank,
  input  logic [MW-1:0] i_mask,
  input  logic [RW-1:0] i_base_reg,
  input  logic [AW-1:0] i_base,
  input  logic          mem_ready,
  output logic          mem_valid,
  output logic [AW-1:0] mem_addr,
  output logic [RW-1:0] mem_reg,
  output logic          mem_load,
  output logic          mem_usr,
  output logic          busy,
  output logic          done,
  output logic          wb_valid,
  output logic [RW-1:0] wb_reg,
  output logic [AW-1:0] wb_data
);
  lsm_state_e    state_q;
  lsm_ctrl_t     ctrl_q;
  logic [MW-1:0] pend_q;
  logic [MW-1:0] scan_in;
  logic [MW-1:0] scan_rest;
  logic [IW-1:0] scan_idx;
  logic          scan_found;
  logic [AW-1:0] first_addr;
  logic [AW-1:0] final_base;
  logic          accept;
  logic          hs;

  assign accept  = (state_q == ST_IDLE) && start;
  assign hs      = (state_q == ST_XFER) && mem_ready;
  assign scan_in = (state_q == ST_IDLE) ? i_mask : pend_q;

  lsm_lowest_scan #(.MW(MW)) u_scan (
    .vec   (scan_in),
    .found (scan_found),
    .idx   (scan_idx),
    .rest  (scan_rest)
  );

  lsm_addr_calc #(.AW(AW), .MW(MW)) u_addr (
    .base       (i_base),
    .mask       (i_mask),
    .pre        (i_pre),
    .up         (i_up),
    .first_addr (first_addr),
    .final_base (final_base)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= ST_IDLE;
      ctrl_q    <= '0;
      pend_q    <= '0;
      mem_valid <= 1'b0;
      mem_addr  <= '0;
      mem_reg   <= '0;
      mem_load  <= 1'b0;
      mem_usr   <= 1'b0;
      done      <= 1'b0;
      wb_valid  <= 1'b0;
      wb_reg    <= '0;
      wb_data   <= '0;
    end else begin
      done     <= 1'b0;
      wb_valid <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (accept) begin
            ctrl_q  <= '{bank: i_bank, wb: i_wb, load: i_load, usr: i_usr};
            wb_reg  <= i_base_reg;
            wb_data <= final_base;
            if (scan_found) begin
              state_q   <= ST_XFER;
              mem_valid <= 1'b1;
              mem_addr  <= first_addr;
              mem_reg   <= {i_bank, scan_idx};
              mem_load  <= i_load;
              mem_usr   <= i_usr;
              pend_q    <= scan_rest;
            end else begin
              state_q  <= ST_DONE;
              done     <= 1'b1;
              wb_valid <= i_wb;
            end
          end
        end
        ST_XFER: begin
          if (hs) begin
            if (scan_found) begin
              mem_addr <= mem_addr + AW'(4);
              mem_reg  <= {ctrl_q.bank, scan_idx};
              pend_q   <= scan_rest;
            end else begin
              state_q   <= ST_DONE;
              mem_valid <= 1'b0;
              done      <= 1'b1;
              wb_valid  <= ctrl_q.wb;
            end
          end
        end
        ST_DONE: state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy = (state_q != ST_IDLE);

  // ---------------- assertions ----------------
  p_hold_r8: assert property (@(posedge clk) disable iff (rst)
    mem_valid && !mem_ready |=> mem_valid && $stable(mem_addr) && $stable(mem_reg))
    else $error("p_hold_r8");

  p_step_r4: assert property (@(posedge clk) disable iff (rst)
    mem_valid && mem_ready && (pend_q != '0) |=> mem_valid && (mem_addr == $past(mem_addr) + AW'(4)))
    else $error("p_step_r4");

  p_ascend_r2: assert property (@(posedge clk) disable iff (rst)
    mem_valid && mem_ready && (pend_q != '0) |=> mem_reg > $past(mem_reg))
    else $error("p_ascend_r2");

  p_bank_r3: assert property (@(posedge clk) disable iff (rst)
    mem_valid |-> mem_reg[RW-1] == ctrl_q.bank)
    else $error("p_bank_r3");

  p_dir_r10: assert property (@(posedge clk) disable iff (rst)
    mem_valid |-> (mem_load == ctrl_q.load) && (mem_usr == ctrl_q.usr))
    else $error("p_dir_r10");

  p_wb_done_r6: assert property (@(posedge clk) disable iff (rst)
    wb_valid |-> done && !mem_valid)
    else $error("p_wb_done_r6");

  p_done_pulse_r9: assert property (@(posedge clk) disable iff (rst)
    done |=> !done)
    else $error("p_done_pulse_r9");

  p_last_done_r9: assert property (@(posedge clk) disable iff (rst)
    mem_valid && mem_ready && (pend_q == '0) |=> done && !mem_valid)
    else $error("p_last_done_r9");

  p_empty_r7: assert property (@(posedge clk) disable iff (rst)
    start && !busy && (i_mask == '0) |=> done && !mem_valid)
    else $error("p_empty_r7");

  p_quiet_r11: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !mem_valid && !done && !wb_valid)
    else $error("p_quiet_r11");

  p_ignore_r1: assert property (@(posedge clk) disable iff (rst)
    mem_valid && !mem_ready && start |=> $stable(mem_reg) && $stable(mem_addr))
    else $error("p_ignore_r1");
endmodule

// File: tb/lsm_sequencer_test.sv
module lsm_sequencer_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic        i_pre = 1'b0, i_up = 1'b0, i_usr = 1'b0, i_wb = 1'b0, i_load = 1'b0, i_bank = 1'b0;
  logic [15:0] i_mask = '0;
  logic [4:0]  i_base_reg = '0;
  logic [31:0] i_base = '0;
  logic        mem_ready = 1'b0;
  logic        mem_valid, mem_load, mem_usr, busy, done, wb_valid;
  logic [31:0] mem_addr, wb_data;
  logic [4:0]  mem_reg, wb_reg;

  int n_run = 0;
  int n_fail = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  lsm_sequencer uut (
    .clk(clk), .rst(rst), .start(start),
    .i_pre(i_pre), .i_up(i_up), .i_usr(i_usr), .i_wb(i_wb), .i_load(i_load), .i_bank(i_bank),
    .i_mask(i_mask), .i_base_reg(i_base_reg), .i_base(i_base),
    .mem_ready(mem_ready), .mem_valid(mem_valid), .mem_addr(mem_addr), .mem_reg(mem_reg),
    .mem_load(mem_load), .mem_usr(mem_usr), .busy(busy), .done(done),
    .wb_valid(wb_valid), .wb_reg(wb_reg), .wb_data(wb_data)
  );

  typedef struct packed {
    logic        p, u, s, w, l, h;
    logic [15:0] mask;
    logic [31:0] base;
    logic [4:0]  rn;
    logic        stall;
  } vec_t;

  localparam int NV = 6;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 16'h0005, 32'h0000_1000, 5'd3,  1'b0},
    '{1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 16'h8001, 32'h0000_2000, 5'd7,  1'b1},
    '{1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 16'h00F0, 32'h0000_3000, 5'd13, 1'b0},
    '{1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 16'hFFFF, 32'h0000_4000, 5'd29, 1'b1},
    '{1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 16'h0100, 32'h0000_0500, 5'd1,  1'b0},
    '{1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 16'h1248, 32'h0000_0100, 5'd30, 1'b1}
  };

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: got %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic drive_start(input vec_t v);
    i_pre = v.p; i_up = v.u; i_usr = v.s; i_wb = v.w; i_load = v.l; i_bank = v.h;
    i_mask = v.mask; i_base = v.base; i_base_reg = v.rn;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  // runs one operation from a falling edge while idle, checks every transfer
  task automatic run_op(input vec_t v);
    int n;
    int got;
    int pos;
    int cyc;
    bit fin;
    logic [31:0] span, ea, ewb;
    n = 0;
    for (int i = 0; i < 16; i++) if (v.mask[i]) n++;
    span = 32'(n) * 32'd4;
    if (v.u) begin
      ea  = v.p ? v.base + 32'd4 : v.base;
      ewb = v.base + span;
    end else begin
      ea  = v.p ? v.base - span : v.base - span + 32'd4;
      ewb = v.base - span;
    end
    got = 0; pos = 0; cyc = 0; fin = 0;
    drive_start(v);
    while (!fin && cyc < 200) begin
      if (done) begin
        chk(got == n, "R9", "transfer count", 32'(got), 32'(n));
        chk(wb_valid == v.w, "R6", "wb_valid", 32'(wb_valid), 32'(v.w));
        if (v.w) begin
          chk(wb_data == ewb, "R6", "wb_data", wb_data, ewb);
          chk(wb_reg == v.rn, "R6", "wb_reg", 32'(wb_reg), 32'(v.rn));
        end
        fin = 1;
      end else if (mem_valid) begin
        while (pos < 16 && !v.mask[pos]) pos++;
        chk(mem_reg == {v.h, 4'(pos)}, "R2", "register index (R3 bank)", 32'(mem_reg), 32'({v.h, 4'(pos)}));
        chk(mem_addr == ea, (got == 0) ? "R5" : "R4", "address", mem_addr, ea);
        chk(mem_load == v.l && mem_usr == v.s, "R10", "direction/user",
            32'({mem_load, mem_usr}), 32'({v.l, v.s}));
        mem_ready = v.stall ? (cyc % 3 == 2) : 1'b1;
        if (mem_ready) begin
          got++; pos++; ea = ea + 32'd4;
        end
      end else begin
        chk(1'b0, "R9", "neither valid nor done", 32'(got), 32'(n));
        fin = 1;
      end
      cyc++;
      @(negedge clk);
    end
    mem_ready = 1'b0;
    chk(!done, "R9", "done pulse length", 32'(done), 32'd0);
  endtask

  initial begin
    #(20 * 20000);
    if (!finished) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    vec_t d;
    repeat (3) @(negedge clk);
    chk({mem_valid, done, wb_valid, busy} == 4'b0, "R11", "outputs in reset",
        32'({mem_valid, done, wb_valid, busy}), 32'd0);
    rst = 1'b0;
    @(negedge clk);
    chk({mem_valid, done, wb_valid, busy} == 4'b0, "R11", "outputs after reset",
        32'({mem_valid, done, wb_valid, busy}), 32'd0);

    for (int k = 0; k < NV; k++) begin
      run_op(VECS[k]);
      @(negedge clk);
    end

    // R7: empty mask, with and without writeback
    d = '{1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 16'h0000, 32'h0000_6000, 5'd9, 1'b0};
    drive_start(d);
    chk(done && !mem_valid, "R7", "empty done/valid", 32'({done, mem_valid}), 32'b10);
    chk(wb_valid && wb_data == 32'h6000, "R7", "empty wb data", wb_data, 32'h6000);
    @(negedge clk);
    chk(!done && !busy, "R7", "empty ends", 32'({done, busy}), 32'd0);
    d.w = 1'b0;
    drive_start(d);
    chk(done && !wb_valid && !mem_valid, "R7", "empty no wb",
        32'({done, wb_valid, mem_valid}), 32'b100);
    @(negedge clk);

    // R1: start while busy ignored
    d = '{1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 16'h0003, 32'h0000_0800, 5'd2, 1'b0};
    drive_start(d);
    d = '{1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 16'h8000, 32'h0000_9000, 5'd4, 1'b0};
    drive_start(d);
    chk(mem_reg == 5'd0 && mem_addr == 32'h800, "R1", "start in flight ignored", mem_addr, 32'h800);
    mem_ready = 1'b1;
    @(negedge clk);
    chk(mem_reg == 5'd1 && mem_addr == 32'h804 && mem_load == 1'b0, "R1", "train continues",
        mem_addr, 32'h804);
    @(negedge clk);
    mem_ready = 1'b0;
    chk(done && !wb_valid, "R1", "original completes", 32'({done, wb_valid}), 32'b10);
    drive_start(d);
    chk(!mem_valid && !done && !busy, "R1", "start in done cycle ignored",
        32'({mem_valid, done, busy}), 32'd0);
    @(negedge clk);

    // R11: reset in the middle of a train
    d = '{1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 16'h00FF, 32'h0000_A000, 5'd5, 1'b0};
    drive_start(d);
    rst = 1'b1;
    @(negedge clk);
    chk({mem_valid, done, wb_valid, busy} == 4'b0, "R11", "mid-train reset",
        32'({mem_valid, done, wb_valid, busy}), 32'd0);
    rst = 1'b0;
    @(negedge clk);
    chk({mem_valid, done, wb_valid, busy} == 4'b0, "R11", "after mid-train reset",
        32'({mem_valid, done, wb_valid, busy}), 32'd0);

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule